// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a clocked requester and an external 16-bit asynchronous static RAM that has byte-lane strobes. Each request carries a read/write flag, an address, a data word and a two-bit byte mask. The block accepts one request at a time through a valid/ready handshake. It then plays out the active-low chip select, output enable, write enable and byte strobes as a timed phase sequence, and it drives the address and the outgoing half of the split data bus. Every phase length is a whole number of clock cycles. Each length is derived at elaboration from a nanosecond limit and the clock period, rounded up.

A write from idle first spends a turnaround phase with output enable high and the data driver off. Write enable then falls, and the masked byte strobes fall in the same cycle. The byte strobes rising ends the word. Write enable, address and data stay put for at least one cycle after that edge. After the hold there is one linger cycle with write enable still low. A second write accepted in that cycle skips the turnaround, so a burst of words is framed purely by the byte strobes. A read holds output enable low with write enable high for the access window, captures the bus on the last cycle of the window, and returns the word with a one-cycle valid pulse.

Top module: `asram_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, ready is high, chip select, output enable, write enable and both byte strobes are high, the data driver is off and read-valid is low.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready is low from the cycle after that edge until the sequence for the request is over.
- R3: For a read, chip select and output enable are low and write enable is high for RD_C cycles (default 2), which is the larger of the rounded-up access time and read cycle time. Each byte strobe is low when its mask bit is set.
- R4: Read data is sampled on the last cycle of the read window. Read-valid is high for exactly one cycle, RD_C cycles after the accept edge. The returned lanes whose mask bit is clear read as zero.
- R5: A write started from idle holds chip select low, output enable high, write enable high and the data driver off for TURN_C cycles (default 1). Write enable falls and the driver switches on in the same cycle, after that phase.
- R6: During the strobe phase, which lasts STROBE_C cycles (default 1, the larger of the rounded-up pulse and data setup times), write enable is low. Mask bit 0 drives the lower strobe (data bits 7:0) low, and mask bit 1 drives the upper strobe (data bits 15:8) low. A mask of 00 writes nothing. Output enable is high whenever write enable is low.
- R7: A word's write is ended by the byte strobes rising while write enable stays low. The address and the driven data do not change in the cycle after that edge.
- R8: A write accepted in the linger cycle after a hold goes straight to the strobe phase. Write enable does not rise between the two words.
- R9: The starts of two consecutive write strobe phases are at least WC_C cycles apart (default 2).
- R10: The data driver is never on while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte mask, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle read-data pulse |
| rd_data | output | 16 | Read word, masked lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned by memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |

## Verification
A phase counter that is off by one shows up on the memory pins within the same request: the read-valid pulse arrives a cycle early or late, or a strobe run has the wrong length. A skipped turnaround is visible on the first write after idle, as write enable falling with no prior cycle of output enable high and the driver off. A wrong phase after the hold shows as write enable rising between burst words, or as address or data changing right after a strobe edge. These are caught at the first such edge. Lane mapping faults corrupt memory contents, and they surface at the next read-back of the affected address.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

    localparam int LANES  = 2;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_STROBE,
        PH_HOLD,
        PH_LINGER,
        PH_READ
    } phase_e;

    typedef struct packed {
        logic                wr;
        logic [LANES-1:0]    be;
        logic [WORD_W-1:0]   data;
    } cmd_t;

    // Round a picosecond limit up to whole clock cycles, never below one.
    function automatic int cyc_of(input int lim_ps, input int clk_ps);
        int c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*BYTE_W +: BYTE_W] = {BYTE_W{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/asram_phase_seq.sv
module asram_phase_seq
    import asram_ctl_pkg::*;
#(
    parameter int TURN_C   = 1,
    parameter int STROBE_C = 1,
    parameter int HOLD_C   = 1,
    parameter int RD_C     = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    output logic   ready,
    output logic   accept,
    output logic   rd_last,
    output phase_e phase
);

    localparam int MAXC = max2(max2(TURN_C, STROBE_C), max2(HOLD_C, RD_C));
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;

    assign ready   = (phase_q == PH_IDLE) || (phase_q == PH_LINGER);
    assign accept  = req_valid && ready;
    assign rd_last = (phase_q == PH_READ) && (cnt_q == '0);
    assign phase   = phase_q;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE, PH_LINGER: begin
                if (req_valid) begin
                    if (!req_write) begin
                        phase_d = PH_READ;
                        cnt_d   = CW'(RD_C - 1);
                    end else if (phase_q == PH_LINGER) begin
                        phase_d = PH_STROBE;
                        cnt_d   = CW'(STROBE_C - 1);
                    end else begin
                        phase_d = PH_TURN;
                        cnt_d   = CW'(TURN_C - 1);
                    end
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            PH_TURN: begin
                if (cnt_q == '0) begin
                    phase_d = PH_STROBE;
                    cnt_d   = CW'(STROBE_C - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    phase_d = PH_HOLD;
                    cnt_d   = CW'(HOLD_C - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) phase_d = PH_LINGER;
                else             cnt_d   = cnt_q - 1'b1;
            end
            PH_READ: begin
                if (cnt_q == '0) phase_d = PH_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

    // R8
    linger_skips_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && phase_q == PH_LINGER) |=> (phase_q == PH_STROBE));

endmodule

// File: rtl/asram_bus_path.sv
module asram_bus_path
    import asram_ctl_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic [LANES-1:0]    req_be,
    input  phase_e              phase,
    input  logic                rd_last,
    input  logic [WORD_W-1:0]   mem_dq_in,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [LANES-1:0]    mem_bs_n
);

    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              strobe_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            cmd_q  <= '{wr: req_write, be: req_be, data: req_wdata};
            addr_q <= req_addr;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = cmd_q.data;
    assign mem_dq_oe  = (phase == PH_STROBE) || (phase == PH_HOLD) || (phase == PH_LINGER);
    assign mem_we_n   = !mem_dq_oe;
    assign mem_oe_n   = (phase != PH_READ);
    assign mem_ce_n   = (phase == PH_IDLE);
    assign strobe_on  = (phase == PH_STROBE) || (phase == PH_READ);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_bs_n[g] = !(strobe_on && cmd_q.be[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_last;
            if (rd_last) rd_data <= mem_dq_in & lane_mask(cmd_q.be);
        end
    end

    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R3
    read_window_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_ctl_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int CLK_PS      = 8000,
    parameter int T_ACC_PS    = 10000,
    parameter int T_RC_PS     = 10000,
    parameter int T_WC_PS     = 10000,
    parameter int T_PWE_PS    = 8000,
    parameter int T_SD_PS     = 6000,
    parameter int T_TURN_PS   = 4000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [15:0]         req_wdata,
    input  logic [1:0]          req_be,
    output logic                rd_valid,
    output logic [15:0]         rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [15:0]         mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [15:0]         mem_dq_in,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n
);

    localparam int TURN_C   = cyc_of(T_TURN_PS, CLK_PS);
    localparam int STROBE_C = max2(cyc_of(T_PWE_PS, CLK_PS), cyc_of(T_SD_PS, CLK_PS));
    localparam int WC_C     = cyc_of(T_WC_PS, CLK_PS);
    localparam int HOLD_C   = max2(1, WC_C - STROBE_C - 1);
    localparam int RD_C     = max2(cyc_of(T_ACC_PS, CLK_PS), cyc_of(T_RC_PS, CLK_PS));

    phase_e           phase;
    logic             accept;
    logic             rd_last;
    logic [LANES-1:0] bs_n;

    asram_phase_seq #(
        .TURN_C  (TURN_C),
        .STROBE_C(STROBE_C),
        .HOLD_C  (HOLD_C),
        .RD_C    (RD_C)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .ready    (req_ready),
        .accept   (accept),
        .rd_last  (rd_last),
        .phase    (phase)
    );

    asram_bus_path #(
        .ADDR_W(ADDR_W)
    ) bus_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .phase     (phase),
        .rd_last   (rd_last),
        .mem_dq_in (mem_dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_bs_n  (bs_n)
    );

    assign mem_lb_n = bs_n[0];
    assign mem_ub_n = bs_n[1];

    // R5
    we_fall_after_turn_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_ce_n) && !$past(mem_dq_oe)));

    // R6
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R7
    hold_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_ub_n && mem_lb_n && !mem_we_n && $past(!mem_we_n)
         && $past(!(mem_ub_n && mem_lb_n)))
        |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

endmodule

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb_top;

    localparam int ADDR_W = 19;
    localparam int RD_C   = 2;
    localparam int WC_C   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic [1:0]        req_be = '0;
    logic              rd_valid;
    logic [15:0]       rd_data;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_dq_out;
    logic              mem_dq_oe;
    logic [15:0]       mem_dq_in;
    logic              mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

    always #4 clk = ~clk;

    asram_ctl #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: 256 words, written at negedges while selected and strobed.
    logic [15:0] mem [0:255];
    int undriven_wr = 0;
    initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

    always @(negedge clk) begin
        if (!rst && !mem_ce_n && !mem_we_n && (!mem_lb_n || !mem_ub_n)) begin
            if (!mem_dq_oe) undriven_wr++;
            if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    always_comb mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 16'hBAD0;

    // Pin-level monitor.
    int  cyc = 0;
    int  contention = 0, oe_in_wr = 0, turn_viol = 0, spacing_viol = 0, hold_viol = 0, we_rises = 0;
    int  last_start = -100;
    logic p_we = 1, p_ce = 1, p_oe = 1, p_dqoe = 0, p_wstb = 0;
    logic [ADDR_W-1:0] p_addr = '0;
    logic [15:0]       p_dq = '0;

    always @(negedge clk) begin
        logic wstb;
        wstb = !mem_we_n && (!mem_lb_n || !mem_ub_n);
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) contention++;
            if (!mem_we_n && !mem_oe_n) oe_in_wr++;
            if (p_we && !mem_we_n && !(!p_ce && p_oe && !p_dqoe)) turn_viol++;
            if (!p_we && mem_we_n) we_rises++;
            if (wstb && !p_wstb) begin
                if (cyc - last_start < WC_C) spacing_viol++;
                last_start = cyc;
            end
            if (p_wstb && !wstb) begin
                if (mem_we_n || !mem_dq_oe || mem_addr != p_addr || mem_dq_out != p_dq) hold_viol++;
            end
        end
        p_we = mem_we_n; p_ce = mem_ce_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe;
        p_wstb = wstb; p_addr = mem_addr; p_dq = mem_dq_out;
        cyc++;
    end

    // Issue one request; called at a negedge, returns at the negedge after acceptance.
    task automatic do_req(input logic wr, input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    endtask

    // Read and check data, latency and window pins.
    task automatic do_read(input logic [7:0] a, input logic [1:0] be, input logic [15:0] exp);
        int  lat;
        bit  win_ok;
        do_req(1'b0, a, 16'h0, be);
        lat = 0; win_ok = 1'b1;
        while (!rd_valid) begin
            if (!(mem_oe_n == 0 && mem_we_n == 1 && mem_ce_n == 0 &&
                  mem_lb_n == !be[0] && mem_ub_n == !be[1])) win_ok = 1'b0;
            lat++;
            @(negedge clk);
        end
        check(win_ok, "R3 read window pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b00100);
        check(lat == RD_C, "R4 read latency", lat, RD_C);
        check(rd_data == exp, "R4 read data", rd_data, exp);
        @(negedge clk);
        check(rd_valid == 1'b0, "R4 valid one cycle", rd_valid, 0);
    endtask

    // {wr, addr[7:0], data[15:0], be[1:0], expected[15:0]}
    localparam logic [42:0] VEC [12] = '{
        {1'b1, 8'h10, 16'hA55A, 2'b11, 16'h0000},
        {1'b1, 8'h11, 16'h1234, 2'b11, 16'h0000},
        {1'b0, 8'h10, 16'h0000, 2'b11, 16'hA55A},
        {1'b0, 8'h11, 16'h0000, 2'b11, 16'h1234},
        {1'b1, 8'h10, 16'h77CC, 2'b01, 16'h0000},
        {1'b0, 8'h10, 16'h0000, 2'b11, 16'hA5CC},
        {1'b1, 8'h11, 16'h9988, 2'b10, 16'h0000},
        {1'b0, 8'h11, 16'h0000, 2'b11, 16'h9934},
        {1'b0, 8'h11, 16'h0000, 2'b01, 16'h0034},
        {1'b0, 8'h10, 16'h0000, 2'b10, 16'hA500},
        {1'b1, 8'h12, 16'h0BEE, 2'b00, 16'h0000},
        {1'b0, 8'h12, 16'h0000, 2'b11, 16'h0000}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R1 control pins",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b11111);
        check(mem_dq_oe == 1'b0 && rd_valid == 1'b0, "R1 driver and valid", {mem_dq_oe, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_ce_n == 1'b1, "R1 first cycle after reset", {req_ready, mem_ce_n}, 2'b11);

        // Table walk (R3 R4 R6 masks and lane mapping)
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][42]) begin
                do_req(1'b1, VEC[i][41:34], VEC[i][33:18], VEC[i][17:16]);
                check(mem_we_n == 1'b1 && mem_oe_n == 1'b1 && mem_dq_oe == 1'b0,
                      "R5 turnaround phase", {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
                @(negedge clk);
                check(mem_we_n == 1'b0 && mem_dq_oe == 1'b1 &&
                      mem_lb_n == !VEC[i][16] && mem_ub_n == !VEC[i][17],
                      "R6 strobe phase pins", {mem_we_n, mem_dq_oe, mem_ub_n, mem_lb_n},
                      {2'b01, !VEC[i][17], !VEC[i][16]});
                repeat (3) @(negedge clk);
            end else begin
                do_read(VEC[i][41:34], VEC[i][17:16], VEC[i][15:0]);
            end
        end

        // R8 back-to-back writes share one write-enable low period
        begin
            int rises0;
            rises0 = we_rises;
            do_req(1'b1, 8'h20, 16'h1111, 2'b11);
            do_req(1'b1, 8'h21, 16'h2222, 2'b11);
            repeat (5) @(negedge clk);
            check(we_rises - rises0 == 1, "R8 we stays low across burst", we_rises - rises0, 1);
        end
        do_read(8'h20, 2'b11, 16'h1111);
        do_read(8'h21, 2'b11, 16'h2222);

        // Read right after a write's linger cycle
        do_req(1'b1, 8'h30, 16'hC3C3, 2'b11);
        repeat (2) @(negedge clk);
        do_read(8'h30, 2'b11, 16'hC3C3);

        repeat (3) @(negedge clk);
        check(contention == 0, "R10 driver vs output enable", contention, 0);
        check(oe_in_wr == 0, "R6 oe high while we low", oe_in_wr, 0);
        check(turn_viol == 0 && undriven_wr == 0, "R5 turnaround before we falls", turn_viol + undriven_wr, 0);
        check(hold_viol == 0, "R7 hold after strobe end", hold_viol, 0);
        check(spacing_viol == 0, "R9 write cycle spacing", spacing_viol, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule